// File: doc/BRIEF.md
# GPIO Interrupt Front End

This block turns a bank of GPIO input lines into one interrupt request for a CPU interrupt controller. Each line passes through a two-stage synchronizer and an optional per-line debounce filter. It then reaches a detector that, per line, applies a sensitivity (level or edge) and a polarity. Lines that are qualified and enabled form the raw status. The mask removes lines from the masked status, and the interrupt output is the OR of the masked status.

Software programs the block through a simple 32-bit register port with a write strobe, a read strobe, an address and write data. Register bit n always belongs to line n. With one line enabled and unmasked, every line set to level sensitivity and all polarity bits high, the block becomes a debounced wire that forwards a single downstream interrupt controller's request to the CPU.

The debounce filter is one small state machine per line with two states. DB_STABLE holds the accepted value. A sample that differs from the accepted value causes the transition "change seen" to DB_SETTLE, and the settle counter starts from zero. In DB_SETTLE, a sample that matches the accepted value again causes the transition "reverted" back to DB_STABLE, and the glitch is dropped. The counter advances on each prescaler tick. When it reaches its limit, the transition "settled" commits the new value and returns to DB_STABLE.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset, every readable register returns 0 and `irq_out` is low.
- R2: The enable (offset 0x30), mask (0x34), sensitivity (0x38) and polarity (0x3C) registers read back the value last written, with bit n controlling line n.
- R3: A line whose sensitivity bit is 0 is level-sensitive. Polarity 1 makes a high input active and polarity 0 makes a low input active. Its status follows the filtered input and is never held.
- R4: A line whose sensitivity bit is 1 is edge-sensitive. Polarity 1 selects the rising edge and polarity 0 the falling edge. The event stays latched until a write to 0x4C with bit n set; writes with bit n clear leave it latched.
- R5: A mask bit of 1 keeps the line visible in the raw status (0x44) but removes it from the masked status (0x40) and from `irq_out`.
- R6: A line whose enable bit is 0 shows no raw status and drives no interrupt, and disabling a line discards any edge it has latched.
- R7: `irq_out` is high exactly when at least one masked status bit is set, one clock after that status.
- R8: An input change that lasts fewer than (DB_CYCLES-1)*DB_DIV clocks never reaches detection. A change held for DB_CYCLES*DB_DIV+4 clocks or more does reach detection.
- R9: Pass-through setup (only line 12 enabled and unmasked, all level, all polarity 1) makes `irq_out` follow line 12 alone.
- R10: Read data appears on `bus_rdata` the clock after `bus_rd`. Reads of 0x4C and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | NUM_LINES | Asynchronous GPIO input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench targets a short glitch on the pass-through line. A filter that commits on the first differing sample would raise the interrupt for that glitch. A latched edge must survive both the input returning to idle and an acknowledge write aimed at other lines; a design that cleared the whole latch on any write, or that treated edge lines as level lines, would drop the event early. A falling-edge line is given a rising edge and must stay quiet, and a latched edge must be gone after the line is disabled and enabled again. A masked but active line must still show up in the raw status while staying out of the masked status and the interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned REG_W = 32;

    // Register byte offsets; software decodes these
    localparam logic [7:0] OFS_ENABLE = 8'h30;
    localparam logic [7:0] OFS_MASK   = 8'h34;
    localparam logic [7:0] OFS_SENSE  = 8'h38;
    localparam logic [7:0] OFS_POL    = 8'h3C;
    localparam logic [7:0] OFS_MSTAT  = 8'h40;
    localparam logic [7:0] OFS_RSTAT  = 8'h44;
    localparam logic [7:0] OFS_ACK    = 8'h4C;

    typedef enum logic {
        DB_STABLE = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter bit          EN     = 1'b1,
    parameter int unsigned CYCLES = 4,
    parameter int unsigned DIV    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    generate
        if (EN) begin : g_filt
            localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
            localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

            logic [DIV_W-1:0] div_q;
            logic             tick;

            assign tick = (div_q == DIV_W'(DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= tick ? '0 : div_q + 1'b1;
            end

            for (genvar i = 0; i < W; i++) begin : g_line
                db_state_e        st_q, st_d;
                logic [CNT_W-1:0] cnt_q, cnt_d;
                logic             val_q, val_d;

                // State register
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        st_q  <= DB_STABLE;
                        cnt_q <= '0;
                        val_q <= 1'b0;
                    end else begin
                        st_q  <= st_d;
                        cnt_q <= cnt_d;
                        val_q <= val_d;
                    end
                end

                // Next state and filtered value
                always_comb begin
                    st_d  = st_q;
                    cnt_d = cnt_q;
                    val_d = val_q;
                    unique case (st_q)
                        DB_STABLE: begin
                            if (raw[i] != val_q) begin
                                st_d  = DB_SETTLE;   // change seen
                                cnt_d = '0;
                            end
                        end
                        DB_SETTLE: begin
                            if (raw[i] == val_q) begin
                                st_d = DB_STABLE;    // reverted
                            end else if (tick) begin
                                if (cnt_q == CNT_W'(CYCLES - 1)) begin
                                    val_d = raw[i];  // settled
                                    st_d  = DB_STABLE;
                                end else begin
                                    cnt_d = cnt_q + 1'b1;
                                end
                            end
                        end
                        default: st_d = DB_STABLE;
                    endcase
                end

                assign clean[i] = val_q;
            end
        end else begin : g_wire
            assign clean = raw;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] en,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] ack,
    output logic [W-1:0] edge_lat,
    output logic [W-1:0] raw_stat
);
    logic [W-1:0] prev_q;
    logic [W-1:0] edge_q;
    logic [W-1:0] lvl_hit;
    logic [W-1:0] edge_hit;

    assign lvl_hit  = ~(din ^ pol);
    assign edge_hit = (din & ~prev_q & pol) | (~din & prev_q & ~pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= din;
            // a new edge wins over an acknowledge in the same cycle
            edge_q <= ((edge_q & ~ack) | edge_hit) & en & sense;
        end
    end

    assign edge_lat = edge_q;
    assign raw_stat = en & ((sense & edge_q) | (~sense & lvl_hit));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [W-1:0]      raw_stat,
    input  logic [W-1:0]      masked_stat,
    output logic [W-1:0]      en,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      sense,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      ack,
    output logic [REG_W-1:0]  rdata
);
    logic [W-1:0]     en_q, mask_q, sense_q, pol_q;
    logic [REG_W-1:0] rdata_q, rmux;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            mask_q  <= '0;
            sense_q <= '0;
            pol_q   <= '0;
        end else if (wr) begin
            if (hit(addr, OFS_ENABLE)) en_q    <= wdata[W-1:0];
            if (hit(addr, OFS_MASK))   mask_q  <= wdata[W-1:0];
            if (hit(addr, OFS_SENSE))  sense_q <= wdata[W-1:0];
            if (hit(addr, OFS_POL))    pol_q   <= wdata[W-1:0];
        end
    end

    assign ack = (wr && hit(addr, OFS_ACK)) ? wdata[W-1:0] : '0;

    always_comb begin
        rmux = '0;
        if      (hit(addr, OFS_ENABLE)) rmux = REG_W'(en_q);
        else if (hit(addr, OFS_MASK))   rmux = REG_W'(mask_q);
        else if (hit(addr, OFS_SENSE))  rmux = REG_W'(sense_q);
        else if (hit(addr, OFS_POL))    rmux = REG_W'(pol_q);
        else if (hit(addr, OFS_MSTAT))  rmux = REG_W'(masked_stat);
        else if (hit(addr, OFS_RSTAT))  rmux = REG_W'(raw_stat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rmux;
    end

    assign en    = en_q;
    assign mask  = mask_q;
    assign sense = sense_q;
    assign pol   = pol_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter bit          DB_EN     = 1'b1,
    parameter int unsigned DB_CYCLES = 4,
    parameter int unsigned DB_DIV    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] gpio_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] sync_in, clean_in;
    logic [NUM_LINES-1:0] en_r, mask_r, sense_r, pol_r, ack_w;
    logic [NUM_LINES-1:0] edge_lat, raw_stat, masked_stat;
    logic                 irq_q;

    gpio_irq_sync #(.W(NUM_LINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(sync_in)
    );

    gpio_irq_debounce #(
        .W(NUM_LINES), .EN(DB_EN), .CYCLES(DB_CYCLES), .DIV(DB_DIV)
    ) u_db (
        .clk(clk), .rst_n(rst_n), .raw(sync_in), .clean(clean_in)
    );

    gpio_irq_detect #(.W(NUM_LINES)) u_det (
        .clk(clk), .rst_n(rst_n), .din(clean_in), .en(en_r), .sense(sense_r),
        .pol(pol_r), .ack(ack_w), .edge_lat(edge_lat), .raw_stat(raw_stat)
    );

    assign masked_stat = raw_stat & ~mask_r;

    gpio_irq_regs #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .raw_stat(raw_stat), .masked_stat(masked_stat),
        .en(en_r), .mask(mask_r), .sense(sense_r), .pol(pol_r), .ack(ack_w),
        .rdata(bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |masked_stat;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/gpio_irq_front_chk.sv
module gpio_irq_front_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] en,
    input logic [W-1:0] mask,
    input logic [W-1:0] sense,
    input logic [W-1:0] ack,
    input logic [W-1:0] edge_lat,
    input logic [W-1:0] masked_stat,
    input logic         irq
);
    AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq); // R6

    AST_OFF_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_lat & ~$past(en)) == '0)); // R6

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_lat & ~ack & en & sense) & ~edge_lat) == '0)); // R4

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_lat & ~$past(sense)) == '0)); // R3

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(masked_stat) != '0)); // R7

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |=> !irq); // R5
endmodule

bind gpio_irq_front gpio_irq_front_chk #(.W(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_r), .mask(mask_r), .sense(sense_r),
    .ack(ack_w), .edge_lat(edge_lat), .masked_stat(masked_stat), .irq(irq_out)
);

// File: tb/gpio_irq_front_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_front_tb_top;
    import gpio_irq_pkg::*;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  gpio = '0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    gpio_irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [31:0] mon_e;
    string       mon_t;

    always @(posedge clk) rd_seen <= rd;

    // Monitor: compare each read result against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected read data: got %h expected none", rdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (rdata !== mon_e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", mon_t, rdata, mon_e);
                end
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Driver: issue a read and push its expected value
    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        @(negedge clk);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", t, irq, e);
        end
    endtask

    task automatic settle();
        repeat (24) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_irq(1'b0, "R1 irq after reset");
        bus_read(OFS_ENABLE, 32'h0, "R1 enable reset");
        bus_read(OFS_MASK,   32'h0, "R1 mask reset");
        bus_read(OFS_SENSE,  32'h0, "R1 sense reset");
        bus_read(OFS_POL,    32'h0, "R1 polarity reset");
        bus_read(OFS_MSTAT,  32'h0, "R1 masked status reset");
        bus_read(OFS_RSTAT,  32'h0, "R1 raw status reset");

        // R2: read back; R10: ack and unmapped read zero
        bus_write(OFS_ENABLE, 32'hA5A5_0F0F);
        bus_write(OFS_MASK,   32'h1234_5678);
        bus_write(OFS_SENSE,  32'hFFFF_0000);
        bus_write(OFS_POL,    32'h0000_FFFF);
        bus_read(OFS_ENABLE, 32'hA5A5_0F0F, "R2 enable readback");
        bus_read(OFS_MASK,   32'h1234_5678, "R2 mask readback");
        bus_read(OFS_SENSE,  32'hFFFF_0000, "R2 sense readback");
        bus_read(OFS_POL,    32'h0000_FFFF, "R2 polarity readback");
        bus_read(OFS_ACK,    32'h0, "R10 ack reads zero");
        bus_read(8'h50,      32'h0, "R10 unmapped reads zero");

        // R9: pass-through of line 12
        bus_write(OFS_MASK,   32'hFFFF_EFFF);
        bus_write(OFS_SENSE,  32'h0);
        bus_write(OFS_POL,    32'hFFFF_FFFF);
        bus_write(OFS_ENABLE, 32'h0000_1000);
        settle();
        check_irq(1'b0, "R9 idle line 12");
        gpio[12] = 1'b1;
        settle();
        check_irq(1'b1, "R9 line 12 high");
        bus_read(OFS_RSTAT, 32'h0000_1000, "R9 raw status");
        bus_read(OFS_MSTAT, 32'h0000_1000, "R9 masked status");
        gpio[5] = 1'b1;
        settle();
        bus_read(OFS_RSTAT, 32'h0000_1000, "R6 disabled line 5 absent");
        gpio[12] = 1'b0;
        settle();
        check_irq(1'b0, "R3 level not held");
        bus_read(OFS_RSTAT, 32'h0, "R3 level status cleared");
        gpio[5] = 1'b0;

        // R8: short glitch filtered
        @(negedge clk);
        gpio[12] = 1'b1;
        repeat (3) @(negedge clk);
        gpio[12] = 1'b0;
        settle();
        check_irq(1'b0, "R8 glitch filtered");
        bus_read(OFS_RSTAT, 32'h0, "R8 glitch not in status");

        // R5: masked line visible in raw only
        bus_write(OFS_ENABLE, 32'h0000_1008);
        gpio[3] = 1'b1;
        settle();
        bus_read(OFS_RSTAT, 32'h0000_0008, "R5 masked line in raw");
        bus_read(OFS_MSTAT, 32'h0, "R5 masked line not in masked");
        check_irq(1'b0, "R5 masked line no irq");
        bus_write(OFS_MASK, 32'hFFFF_EFF7);
        settle();
        bus_read(OFS_MSTAT, 32'h0000_0008, "R5 unmasked line");
        check_irq(1'b1, "R5 unmasked irq");

        // R7: OR of two lines
        gpio[12] = 1'b1;
        settle();
        check_irq(1'b1, "R7 two lines active");
        gpio[3] = 1'b0;
        settle();
        check_irq(1'b1, "R7 one line still active");
        gpio[12] = 1'b0;
        settle();
        check_irq(1'b0, "R7 no line active");

        // R3: active-low level on line 7
        bus_write(OFS_MASK,   32'h0);
        bus_write(OFS_POL,    32'hFFFF_FF7F);
        bus_write(OFS_ENABLE, 32'h0000_0080);
        settle();
        check_irq(1'b1, "R3 low-active line 7 low");
        bus_read(OFS_RSTAT, 32'h0000_0080, "R3 low-active raw");
        gpio[7] = 1'b1;
        settle();
        check_irq(1'b0, "R3 low-active line 7 high");

        // R4: rising edge on line 20
        bus_write(OFS_POL,    32'hFFFF_FFFF);
        bus_write(OFS_SENSE,  32'h0010_0000);
        bus_write(OFS_ENABLE, 32'h0010_0000);
        settle();
        bus_read(OFS_RSTAT, 32'h0, "R4 no edge yet");
        gpio[20] = 1'b1;
        settle();
        bus_read(OFS_RSTAT, 32'h0010_0000, "R4 rising edge latched");
        check_irq(1'b1, "R4 edge irq");
        gpio[20] = 1'b0;
        settle();
        bus_read(OFS_RSTAT, 32'h0010_0000, "R4 latch survives input drop");
        bus_write(OFS_ACK, 32'hFFEF_FFFF);
        settle();
        bus_read(OFS_RSTAT, 32'h0010_0000, "R4 other ack bits ignored");
        bus_write(OFS_ACK, 32'h0010_0000);
        settle();
        bus_read(OFS_RSTAT, 32'h0, "R4 ack clears");
        check_irq(1'b0, "R4 irq after ack");

        // R4: falling edge on line 21
        bus_write(OFS_POL,    32'hFFDF_FFFF);
        bus_write(OFS_SENSE,  32'h0030_0000);
        bus_write(OFS_ENABLE, 32'h0020_0000);
        settle();
        gpio[21] = 1'b1;
        settle();
        bus_read(OFS_RSTAT, 32'h0, "R4 rising ignored on falling line");
        gpio[21] = 1'b0;
        settle();
        bus_read(OFS_RSTAT, 32'h0020_0000, "R4 falling edge latched");

        // R6: disabling drops the latch
        bus_write(OFS_ENABLE, 32'h0);
        settle();
        bus_read(OFS_RSTAT, 32'h0, "R6 disabled raw empty");
        check_irq(1'b0, "R6 disabled no irq");
        bus_write(OFS_ENABLE, 32'h0020_0000);
        settle();
        bus_read(OFS_RSTAT, 32'h0, "R6 latch discarded");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 pending reads: got %0d expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule